// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block connects a host's I/O write and read cycles to a printer with a byte-wide parallel interface. The host writes a byte to the data port and then writes to the strobe port. The block holds the byte on the printer data lines for a setup interval. It then pulls the strobe line low for a fixed width and waits for the printer's acknowledge. The host follows the transfer by polling a status port. That port reports the synchronised BUSY level, whether an acknowledge arrived, and whether a new byte may be sent.

Some printers misread the data lines if they keep the old byte after acknowledging. To avoid this, the block drives the lines to 00H as soon as the acknowledge is seen. It keeps them at zero until the printer drops BUSY. Every acknowledge also lights an activity LED for a stretched interval, so that a short pulse can be seen.

Top module: `prn_port_ctrl`

## Requirements
- R1: After reset the printer data lines are 00H, the strobe line is high, the LED is off, and the status byte is 04H while BUSY is low.
- R2: In the idle state, a write to offset C latches the byte. The byte appears on the printer data lines on the next cycle and is read back at offset C.
- R3: In the idle state, a write to offset D starts a transfer. The strobe stays high for exactly STB_CYCLES cycles of setup, goes low for exactly STB_CYCLES cycles, and then returns high.
- R4: The latched byte stays unchanged on the data lines through the setup, strobe and acknowledge-wait phases.
- R5: When the active-low acknowledge input asserts during the acknowledge wait, the data lines go to 00H and the ack-seen status bit sets. The input passes a two-stage synchroniser first.
- R6: After an acknowledge, the port stays non-idle (ready = 0) and the data lines stay 00H while BUSY is high. The port returns to idle only after BUSY goes low. The lines then stay 00H until the next data write.
- R7: Offset B reads the status byte. Bit 0 is the synchronised BUSY, bit 1 is ack-seen, bit 2 is ready (idle and BUSY low), and bits 7:3 are zero. A write to offset D clears ack-seen.
- R8: Writes to offset C or D while the port is not idle are ignored. The data lines keep their value and no extra strobe is produced.
- R9: Each acknowledge assertion drives the LED output high for LED_CYCLES cycles. A new acknowledge restarts the interval.
- R10: Reads at any offset other than B and C return 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 4 | Port offset within the 16-port block |
| host_wr_i | input | 1 | Write enable for one cycle |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data for host_addr_i (combinational) |
| prn_data_o | output | 8 | Printer data lines |
| prn_strobe_no | output | 1 | Printer strobe, active low |
| prn_ack_ni | input | 1 | Printer acknowledge, active low, asynchronous |
| prn_busy_i | input | 1 | Printer busy, active high, asynchronous |
| ack_led_o | output | 1 | Stretched acknowledge activity LED |

## Verification
A wrong sequencer state shows up at the ports within one transfer:
- a setup or strobe counter that is off by one changes the measured high or low width of the strobe;
- a missed or late acknowledge leaves the old byte on the data lines, where the bench reads it a few cycles after the synchroniser delay;
- leaving the zero phase early sets the ready bit while BUSY is still high.

Every one of the 256 byte values is sent through a full transfer, so a stuck or crossed data bit is also caught, along with writes that are not ignored outside the idle state.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_WAIT_ACK, ST_ZERO
  } prn_state_e;

  localparam int STAT_BUSY = 0;
  localparam int STAT_ACK  = 1;
  localparam int STAT_RDY  = 2;
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/prn_stretch.sv
module prn_stretch #(
  parameter int LEN = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic led_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (trig_i) cnt_q <= CW'(LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign led_o = (cnt_q != '0);

  p_led_on_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> led_o);
  p_led_decays_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !led_o) |=> !led_o);
endmodule

// File: rtl/prn_seq.sv
module prn_seq
  import prn_pkg::*;
#(
  parameter int STB_CYCLES = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       data_we_i,
  input  logic       stb_we_i,
  input  logic [7:0] wdata_i,
  input  logic       ack_evt_i,
  input  logic       busy_i,
  output logic [7:0] data_o,
  output logic       strobe_no,
  output logic       idle_o,
  output logic       ack_seen_o
);
  localparam int CW = (STB_CYCLES > 1) ? $clog2(STB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(STB_CYCLES - 1);

  prn_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    data_q;
  logic          ack_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      data_q     <= '0;
      ack_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (data_we_i) data_q <= wdata_i;
          if (stb_we_i) begin
            state_q    <= ST_SETUP;
            cnt_q      <= CNT_LOAD;
            ack_seen_q <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_STROBE;
            cnt_q   <= CNT_LOAD;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_STROBE: begin
          if (cnt_q == '0) state_q <= ST_WAIT_ACK;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_WAIT_ACK: begin
          if (ack_evt_i) begin
            state_q    <= ST_ZERO;
            data_q     <= '0;
            ack_seen_q <= 1'b1;
          end
        end
        ST_ZERO: if (!busy_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o     = data_q;
  assign strobe_no  = (state_q != ST_STROBE);
  assign idle_o     = (state_q == ST_IDLE);
  assign ack_seen_o = ack_seen_q;

  // R3: strobe held for the full count
  p_strobe_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && cnt_q != '0) |=> !strobe_no);
  p_strobe_from_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> $past(state_q) == ST_SETUP);
  // R4: byte frozen while it is being presented
  p_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP || state_q == ST_STROBE) |=> $stable(data_o));
  // R5/R6: lines zero during post-ack phase
  p_zero_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO) |-> (data_o == 8'h00));
  p_hold_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO && busy_i) |=> (state_q == ST_ZERO));
endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
  import prn_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int          STB_CYCLES = 50,
  parameter int          LED_CYCLES = 2_500_000,
  parameter int          SYNC_STG   = 2,
  parameter logic [3:0]  OFS_STAT   = 4'hB,
  parameter logic [3:0]  OFS_DATA   = 4'hC,
  parameter logic [3:0]  OFS_STB    = 4'hD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic [7:0]        prn_data_o,
  output logic              prn_strobe_no,
  input  logic              prn_ack_ni,
  input  logic              prn_busy_i,
  output logic              ack_led_o
);
  logic [1:0] sync_q;
  logic       busy_s, ack_s, ack_d_q, ack_evt;
  logic       data_we, stb_we, idle, ack_seen;
  logic [7:0] status;

  prn_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({prn_busy_i, ~prn_ack_ni}),
    .q_o   (sync_q)
  );
  assign {busy_s, ack_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_d_q <= 1'b0;
    else ack_d_q <= ack_s;
  end
  assign ack_evt = ack_s & ~ack_d_q;

  assign data_we = host_wr_i && (host_addr_i == ADDR_W'(OFS_DATA));
  assign stb_we  = host_wr_i && (host_addr_i == ADDR_W'(OFS_STB));

  prn_seq #(.STB_CYCLES(STB_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_we_i (data_we),
    .stb_we_i  (stb_we),
    .wdata_i   (host_wdata_i),
    .ack_evt_i (ack_evt),
    .busy_i    (busy_s),
    .data_o    (prn_data_o),
    .strobe_no (prn_strobe_no),
    .idle_o    (idle),
    .ack_seen_o(ack_seen)
  );

  prn_stretch #(.LEN(LED_CYCLES)) u_led (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(ack_evt),
    .led_o (ack_led_o)
  );

  always_comb begin
    status            = '0;
    status[STAT_BUSY] = busy_s;
    status[STAT_ACK]  = ack_seen;
    status[STAT_RDY]  = idle & ~busy_s;
  end

  always_comb begin
    if (host_addr_i == ADDR_W'(OFS_STAT))      host_rdata_o = status;
    else if (host_addr_i == ADDR_W'(OFS_DATA)) host_rdata_o = prn_data_o;
    else                                       host_rdata_o = 8'h00;
  end

  p_ready_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[STAT_RDY] |-> !busy_s);
  p_no_strobe_when_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[STAT_RDY] |-> prn_strobe_no);
endmodule

// File: tb/tb_prn_port_ctrl.sv
module tb_prn_port_ctrl;
  localparam int STB = 4;
  localparam int LED = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pdata;
  logic       strobe_n, led;
  logic       ack_n = 1'b1;
  logic       busy = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  prn_port_ctrl #(.STB_CYCLES(STB), .LED_CYCLES(LED)) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wr_i(wr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .prn_data_o(pdata),
    .prn_strobe_no(strobe_n), .prn_ack_ni(ack_n), .prn_busy_i(busy),
    .ack_led_o(led)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse();
    ack_n = 1'b0; wait_n(3); ack_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int hi, lo;
    bit acked = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 data", pdata, 0);
    chk("R1 strobe", strobe_n, 1);
    chk("R1 led", led, 0);
    rd(4'hB, r); chk("R1 status", r, 8'h04);
    // R10 unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a != 11 && a != 12) begin
        rd(4'(a), r); chk("R10 unmapped read", r, 0);
      end
    end

    for (int b = 0; b < 256; b++) begin
      host_wr(4'hC, 8'(b));
      chk("R2 data lines", pdata, b);
      rd(4'hC, r); chk("R2 readback", r, b);
      rd(4'hB, r); chk("R7 idle status", r, acked ? 8'h06 : 8'h04);
      host_wr(4'hD, 8'hFF);
      rd(4'hB, r); chk("R7 ack_seen cleared, not ready", r, 8'h00);
      hi = 0;
      while (strobe_n && hi < 50) begin hi++; @(negedge clk); end
      chk("R3 setup width", hi, STB);
      chk("R4 data at strobe", pdata, b);
      lo = 0;
      while (!strobe_n && lo < 50) begin lo++; @(negedge clk); end
      chk("R3 strobe width", lo, STB);
      busy = 1'b1;
      wait_n(3);
      chk("R4 data while waiting", pdata, b);
      rd(4'hB, r); chk("R7 busy status", r, 8'h01);
      // R8: writes while busy are ignored
      host_wr(4'hC, ~8'(b));
      chk("R8 data write ignored", pdata, b);
      host_wr(4'hD, 8'h00);
      hi = 0;
      for (int k = 0; k < 2*STB + 2; k++) begin
        if (!strobe_n) hi++;
        @(negedge clk);
      end
      chk("R8 no second strobe", hi, 0);
      ack_pulse();
      wait_n(3);
      chk("R5 data zeroed", pdata, 0);
      rd(4'hB, r); chk("R5 ack_seen with busy", r, 8'h03);
      chk("R9 led lit", led, 1);
      wait_n(5);
      chk("R6 zero while busy", pdata, 0);
      rd(4'hB, r); chk("R6 not ready while busy", r, 8'h03);
      busy = 1'b0;
      wait_n(4);
      rd(4'hB, r); chk("R6 idle after busy drop", r, 8'h06);
      chk("R6 zero after idle", pdata, 0);
      acked = 1;
      wait_n(LED + 2);
      chk("R9 led off", led, 0);
    end

    // R9 exact width and retrigger
    ack_pulse();
    hi = 0;
    for (int k = 0; k < LED + 10; k++) begin
      if (led) hi++;
      @(negedge clk);
    end
    chk("R9 led width", hi, LED);
    ack_pulse();
    wait_n(10);
    ack_pulse();
    wait_n(LED - 5);
    chk("R9 retrigger extends", led, 1);
    wait_n(10);
    chk("R9 retrigger ends", led, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule